// File: doc/BRIEF.md
# SAR ADC Trigger and Track Controller

This block is the digital side of a successive-approximation analog-to-digital converter. Software sets it up through one 8-bit control register. That register holds an enable, a track-mode bit, a start-mode field, a busy bit, a completion flag, a window flag and a justify bit.

A conversion can be started in four ways:

- a software write,
- an overflow pulse from either of two timers,
- a rising edge on an asynchronous convert-start pin.

Before each conversion the analog front end samples the input for a track window. The block drives that window on `track_o` and then resolves the result one bit at a time. During the resolve it presents a trial code on `dac_code` and reads back a single comparator bit.

The finished code is shown in a 16-bit high/low data pair, aligned to the right or to the left. When busy falls, the block sets a sticky completion flag, and that flag drives the interrupt output. A separate sticky window flag is set by an external match strobe and is cleared by software.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After a synchronous reset the control register reads 0x00, `conv_irq`, `track_o` and `dac_code` are 0, and the data pair reads 0x0000.
- R2: The control register layout is: bit7 enable, bit6 track mode, bit5 completion flag, bit4 busy, bits3-2 start mode, bit1 window flag, bit0 left-justify. The writable fields read back as written.
- R3: Start mode 00 starts a conversion on a write whose byte has enable=1, start mode 00 and bit4=1. A write with bit4=0 never starts a conversion.
- R4: Start mode 01 starts on a one-cycle `tmr_a_ovf` pulse, and start mode 11 starts on a one-cycle `tmr_b_ovf` pulse. The pulse of the timer not selected is ignored.
- R5: Start mode 10 synchronises `cnv_pin` through two flops and starts the conversion one cycle after the synchronised rising edge. With track mode 1 and no conversion running, `track_o` follows the synchronised pin being low. A pin held high does not start again.
- R6: With track mode 1 and start mode 00, 01 or 11, a trigger gives exactly 3 cycles of `track_o` followed by 10 conversion cycles. Busy reads 1 for all 13 cycles.
- R7: With track mode 0, `track_o` is 1 whenever the block is enabled and busy is 0. A trigger goes straight to conversion, so busy lasts 10 cycles with `track_o` low.
- R8: The result is resolved MSB first. A trial bit is kept when `cmp_in` is 1, meaning the input is at or above `dac_code`, so the result equals the input code.
- R9: When busy falls, the completion flag (bit5) and `conv_irq` are set. They stay set until a write with bit5=0; a write with bit5=1 leaves them unchanged.
- R10: With bit0=0 the data pair is right-aligned (high byte = {6'b0, res[9:8]}, low byte = res[7:0]). With bit0=1 it is left-aligned (high byte = res[9:2], low byte = {res[1:0], 6'b0}).
- R11: With enable=0, no trigger of any kind starts a conversion and `track_o` stays 0.
- R12: A trigger that arrives while busy is 1 is ignored. The running conversion keeps its length and no second conversion follows.
- R13: A one-cycle `win_hit` sets the window flag (bit1). It stays set until a write with bit1=0; a write with bit1=1 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one SAR step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value, including live busy |
| tmr_a_ovf | input | 1 | First timer overflow pulse (start mode 01) |
| tmr_b_ovf | input | 1 | Second timer overflow pulse (start mode 11) |
| cnv_pin | input | 1 | Asynchronous convert-start pin (start mode 10) |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| win_hit | input | 1 | Window match strobe |
| track_o | output | 1 | Tracking window for the sample circuit |
| dac_code | output | 10 | Current trial code |
| data_hi | output | 8 | High byte of the result pair |
| data_lo | output | 8 | Low byte of the result pair |
| conv_irq | output | 1 | Completion interrupt, equal to the completion flag |

## Verification
Inputs are driven and outputs sampled on the falling edge. A write or timer pulse that is seen at rising edge k shows busy and the first track cycle in the sample just after k. In track mode 1 the completion flag and the new data pair appear 13 samples later; in track mode 0 they appear after 10. The bench counts consecutive busy samples, and the `track_o` samples among them, instead of waiting a fixed time, so a window that is one cycle too long or too short is reported. A pin edge is sampled on each of the three following edges: tracking drops after the second and busy rises after the third. Register-side effects such as flags and justification are read in the sample right after the write edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Control byte field positions (software decodes these)
  localparam int unsigned F_EN   = 7;
  localparam int unsigned F_TM   = 6;
  localparam int unsigned F_CF   = 5;
  localparam int unsigned F_BSY  = 4;
  localparam int unsigned F_SMHI = 3;
  localparam int unsigned F_SMLO = 2;
  localparam int unsigned F_WF   = 1;
  localparam int unsigned F_LJ   = 0;

  typedef enum logic [1:0] {
    SM_SOFT  = 2'b00,
    SM_TMR_A = 2'b01,
    SM_PIN   = 2'b10,
    SM_TMR_B = 2'b11
  } start_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_TRACK = 2'b01,
    ST_CONV  = 2'b10
  } seq_state_e;

endpackage

// File: rtl/adc_cnv_sync.sv
module adc_cnv_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic pin_lvl,
  output logic pin_rise
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  // Chain resets to the idle-high level so reset never fakes an edge
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b1;
        else     chain_q[0] <= pin_async;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= 1'b1;
        else     chain_q[i] <= chain_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= chain_q[LAST];
  end

  assign pin_lvl  = chain_q[LAST];
  assign pin_rise = chain_q[LAST] & ~last_q;

endmodule

// File: rtl/adc_ctl_reg.sv
module adc_ctl_reg
  import adc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [7:0]  wdata,
  input  logic        busy,
  input  logic        fin,
  input  logic        win_hit,
  output logic        en_q,
  output logic        tm_q,
  output start_mode_e sm_q,
  output logic        lj_q,
  output logic        eff_en,
  output logic        eff_tm,
  output start_mode_e eff_sm,
  output logic        sw_go,
  output logic        cflag_q,
  output logic [7:0]  rdata
);
  logic wflag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      tm_q <= 1'b0;
      sm_q <= SM_SOFT;
      lj_q <= 1'b0;
    end else if (wr) begin
      en_q <= wdata[F_EN];
      tm_q <= wdata[F_TM];
      sm_q <= start_mode_e'(wdata[F_SMHI:F_SMLO]);
      lj_q <= wdata[F_LJ];
    end
  end

  // R9: set by completion wins over a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (rst)                       cflag_q <= 1'b0;
    else if (fin)                  cflag_q <= 1'b1;
    else if (wr && !wdata[F_CF])   cflag_q <= 1'b0;
  end

  // R13: sticky window flag
  always_ff @(posedge clk) begin
    if (rst)                       wflag_q <= 1'b0;
    else if (win_hit)              wflag_q <= 1'b1;
    else if (wr && !wdata[F_WF])   wflag_q <= 1'b0;
  end

  // Settings in force for a trigger this cycle (a write takes effect at once)
  always_comb begin
    if (wr) begin
      eff_en = wdata[F_EN];
      eff_tm = wdata[F_TM];
      eff_sm = start_mode_e'(wdata[F_SMHI:F_SMLO]);
    end else begin
      eff_en = en_q;
      eff_tm = tm_q;
      eff_sm = sm_q;
    end
  end

  // R3: only a byte with enable, busy=1 and soft mode starts
  assign sw_go = wr && wdata[F_BSY] && wdata[F_EN] &&
                 (start_mode_e'(wdata[F_SMHI:F_SMLO]) == SM_SOFT);

  assign rdata = {en_q, tm_q, cflag_q, busy, sm_q, wflag_q, lj_q};

endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W     = 10,
  parameter int unsigned TRACK_CYC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_q,
  input  logic             tm_q,
  input  start_mode_e      sm_q,
  input  logic             eff_en,
  input  logic             eff_tm,
  input  start_mode_e      eff_sm,
  input  logic             sw_go,
  input  logic             tmr_a,
  input  logic             tmr_b,
  input  logic             pin_rise,
  input  logic             pin_lvl,
  input  logic             cmp_in,
  output logic             busy,
  output logic             track,
  output logic             fin,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] result
);
  localparam int unsigned TW = (TRACK_CYC > 1) ? $clog2(TRACK_CYC) : 1;
  localparam logic [RES_W-1:0] MSB = {1'b1, {(RES_W-1){1'b0}}};

  seq_state_e       st_q;
  logic [TW-1:0]    tcnt_q;
  logic [RES_W-1:0] mask_q;
  logic [RES_W-1:0] trial_q;
  logic [RES_W-1:0] res_q;
  logic             src_hit;
  logic             trig;
  logic             with_track;
  logic [RES_W-1:0] kept;

  always_comb begin
    unique case (eff_sm)
      SM_SOFT:  src_hit = sw_go;
      SM_TMR_A: src_hit = tmr_a;
      SM_PIN:   src_hit = pin_rise;
      default:  src_hit = tmr_b;
    endcase
  end

  // R11: gated by enable; R12: only accepted from idle
  assign trig       = eff_en && src_hit && (st_q == ST_IDLE);
  assign with_track = eff_tm && (eff_sm != SM_PIN);
  assign kept       = cmp_in ? trial_q : (trial_q & ~mask_q);
  assign fin        = (st_q == ST_CONV) && mask_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      tcnt_q  <= '0;
      mask_q  <= '0;
      trial_q <= '0;
      res_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (trig) begin
            if (with_track) begin
              st_q   <= ST_TRACK;
              tcnt_q <= TW'(TRACK_CYC - 1);
            end else begin
              st_q    <= ST_CONV;
              mask_q  <= MSB;
              trial_q <= MSB;
            end
          end
        end
        ST_TRACK: begin
          if (tcnt_q == '0) begin
            st_q    <= ST_CONV;
            mask_q  <= MSB;
            trial_q <= MSB;
          end else begin
            tcnt_q <= tcnt_q - 1'b1;
          end
        end
        ST_CONV: begin
          if (mask_q[0]) begin
            res_q   <= kept;
            st_q    <= ST_IDLE;
            mask_q  <= '0;
            trial_q <= '0;
          end else begin
            trial_q <= kept | (mask_q >> 1);
            mask_q  <= mask_q >> 1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign trial  = trial_q;
  assign result = res_q;

  // Idle tracking: always in track mode 0, pin-low only in pin mode with track mode 1
  assign track = (st_q == ST_TRACK) ||
                 ((st_q == ST_IDLE) && en_q &&
                  (!tm_q || ((sm_q == SM_PIN) && !pin_lvl)));

endmodule

// File: rtl/adc_res_fmt.sv
module adc_res_fmt #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic [RES_W-1:0]  res,
  input  logic              left,
  output logic [DATA_W-1:0] hi,
  output logic [DATA_W-1:0] lo
);
  localparam int unsigned PAIR_W = 2 * DATA_W;
  localparam int unsigned PAD    = PAIR_W - RES_W;

  logic [PAIR_W-1:0] r_al;
  logic [PAIR_W-1:0] l_al;
  logic [PAIR_W-1:0] pair;

  if (PAD == 0) begin : g_full
    assign r_al = res;
    assign l_al = res;
  end else begin : g_pad
    assign r_al = {{PAD{1'b0}}, res};
    assign l_al = {res, {PAD{1'b0}}};
  end

  assign pair = left ? l_al : r_al;
  assign hi   = pair[PAIR_W-1:DATA_W];
  assign lo   = pair[DATA_W-1:0];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W       = 10,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned TRACK_CYC   = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              tmr_a_ovf,
  input  logic              tmr_b_ovf,
  input  logic              cnv_pin,
  input  logic              cmp_in,
  input  logic              win_hit,
  output logic              track_o,
  output logic [RES_W-1:0]  dac_code,
  output logic [DATA_W-1:0] data_hi,
  output logic [DATA_W-1:0] data_lo,
  output logic              conv_irq
);
  logic             pin_lvl, pin_rise;
  logic             en_q, tm_q, lj_q;
  start_mode_e      sm_q, eff_sm;
  logic             eff_en, eff_tm, sw_go;
  logic             busy, fin, cflag;
  logic [RES_W-1:0] result;

  adc_cnv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_async(cnv_pin),
    .pin_lvl(pin_lvl), .pin_rise(pin_rise)
  );

  adc_ctl_reg u_reg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata),
    .busy(busy), .fin(fin), .win_hit(win_hit),
    .en_q(en_q), .tm_q(tm_q), .sm_q(sm_q), .lj_q(lj_q),
    .eff_en(eff_en), .eff_tm(eff_tm), .eff_sm(eff_sm),
    .sw_go(sw_go), .cflag_q(cflag), .rdata(cfg_rdata)
  );

  adc_sar_seq #(.RES_W(RES_W), .TRACK_CYC(TRACK_CYC)) u_seq (
    .clk(clk), .rst(rst),
    .en_q(en_q), .tm_q(tm_q), .sm_q(sm_q),
    .eff_en(eff_en), .eff_tm(eff_tm), .eff_sm(eff_sm),
    .sw_go(sw_go), .tmr_a(tmr_a_ovf), .tmr_b(tmr_b_ovf),
    .pin_rise(pin_rise), .pin_lvl(pin_lvl), .cmp_in(cmp_in),
    .busy(busy), .track(track_o), .fin(fin),
    .trial(dac_code), .result(result)
  );

  adc_res_fmt #(.RES_W(RES_W), .DATA_W(DATA_W)) u_fmt (
    .res(result), .left(lj_q), .hi(data_hi), .lo(data_lo)
  );

  assign conv_irq = cflag;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int unsigned RES_W     = 10,
  parameter int unsigned TRACK_CYC = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       cfg_wr,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_rdata,
  input logic       win_hit,
  input logic       conv_irq
);
  localparam int unsigned LIMIT = TRACK_CYC + RES_W;
  localparam int unsigned CW    = $clog2(LIMIT + 2);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)               run_q <= '0;
    else if (cfg_rdata[4]) run_q <= (run_q == CW'(LIMIT + 1)) ? run_q : run_q + 1'b1;
    else                   run_q <= '0;
  end

  // R6 / R12: no busy run exceeds track plus conversion length
  a_r6_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[4] |-> (run_q < CW'(LIMIT)));

  // R9: the falling edge of busy leaves the flag and the interrupt set
  a_r9_fall_flags: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_rdata[4]) |-> (cfg_rdata[5] && conv_irq));

  // R11: disabled and idle stays idle
  a_r11_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (!cfg_rdata[7] && !cfg_rdata[4] && !cfg_wr) |=> !cfg_rdata[4]);

  // R3: a soft-mode write with bit4 clear starts nothing
  a_r3_zero_noop: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_wdata[4] && (cfg_wdata[3:2] == 2'b00) && !cfg_rdata[4])
    |=> !cfg_rdata[4]);

  // R13: a match strobe sets the window flag
  a_r13_win_sets: assert property (@(posedge clk) disable iff (rst)
    win_hit |=> cfg_rdata[1]);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES_W(RES_W), .TRACK_CYC(TRACK_CYC)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .win_hit(win_hit), .conv_irq(conv_irq)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       tmr_a_ovf = 1'b0, tmr_b_ovf = 1'b0, cnv_pin = 1'b0, win_hit = 1'b0;
  logic       cmp_in, track_o, conv_irq;
  logic [9:0] dac_code;
  logic [9:0] vin = 10'd0;
  logic [7:0] data_hi, data_lo;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Comparator model: input at or above trial code
  assign cmp_in = (vin >= dac_code);

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tmr_a_ovf(tmr_a_ovf), .tmr_b_ovf(tmr_b_ovf),
    .cnv_pin(cnv_pin), .cmp_in(cmp_in), .win_hit(win_hit),
    .track_o(track_o), .dac_code(dac_code), .data_hi(data_hi),
    .data_lo(data_lo), .conv_irq(conv_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = b;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic pulse_a();
    @(negedge clk); tmr_a_ovf = 1'b1;
    @(negedge clk); tmr_a_ovf = 1'b0;
  endtask

  task automatic pulse_b();
    @(negedge clk); tmr_b_ovf = 1'b1;
    @(negedge clk); tmr_b_ovf = 1'b0;
  endtask

  // Counts consecutive busy samples from the current one; pokes tmr_a at index poke
  task automatic measure(input int poke, output int nb, output int nt);
    nb = 0; nt = 0;
    while (cfg_rdata[4] && nb < 40) begin
      tmr_a_ovf = (nb == poke);
      nb++;
      if (track_o) nt++;
      @(negedge clk);
    end
    tmr_a_ovf = 1'b0;
  endtask

  task automatic idle_for(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, cfg_rdata[4], 0);
    end
  endtask

  task automatic t_reset();
    chk("R1 ctl", cfg_rdata, 8'h00);
    chk("R1 irq", conv_irq, 0);
    chk("R1 track", track_o, 0);
    chk("R1 dac", dac_code, 0);
    chk("R1 data", {data_hi, data_lo}, 16'h0000);
  endtask

  task automatic t_layout();
    wr(8'h4D);
    chk("R2 readback", cfg_rdata, 8'h4D);
  endtask

  task automatic t_soft_tm1();
    int nb, nt;
    vin = 10'h2A5;
    wr(8'hD0);
    measure(-1, nb, nt);
    chk("R6 busy len", nb, 13);
    chk("R6 track len", nt, 3);
    chk("R9 flag", cfg_rdata[5], 1);
    chk("R9 irq", conv_irq, 1);
    chk("R8 R10 right hi", data_hi, 8'h02);
    chk("R8 R10 right lo", data_lo, 8'hA5);
    chk("R6 idle track", track_o, 0);
  endtask

  task automatic t_flags();
    wr(8'hE0);
    chk("R3 zero write", cfg_rdata[4], 0);
    chk("R9 write1 keeps", cfg_rdata[5], 1);
    wr(8'hC0);
    chk("R9 clear flag", cfg_rdata[5], 0);
    chk("R9 clear irq", conv_irq, 0);
    idle_for(3, "R3 no start");
  endtask

  task automatic t_justify();
    wr(8'hC1);
    chk("R10 left hi", data_hi, 8'hA9);
    chk("R10 left lo", data_lo, 8'h40);
    wr(8'hC0);
    chk("R10 back right", data_hi, 8'h02);
  endtask

  task automatic t_tm0();
    int nb, nt;
    vin = 10'h3FF;
    wr(8'h90);
    measure(-1, nb, nt);
    chk("R7 busy len", nb, 10);
    chk("R7 no track busy", nt, 0);
    chk("R7 idle track", track_o, 1);
    chk("R8 full hi", data_hi, 8'h03);
    chk("R8 full lo", data_lo, 8'hFF);
  endtask

  task automatic t_timers();
    int nb, nt;
    vin = 10'h000;
    wr(8'hC4);
    pulse_b();
    chk("R4 other timer", cfg_rdata[4], 0);
    pulse_a();
    measure(5, nb, nt);
    chk("R4 R12 busy len", nb, 13);
    idle_for(4, "R12 no retrigger");
    chk("R8 zero", {data_hi, data_lo}, 16'h0000);
    vin = 10'h155;
    wr(8'hCC);
    pulse_a();
    chk("R4 mode11 ignores a", cfg_rdata[4], 0);
    pulse_b();
    measure(-1, nb, nt);
    chk("R4 mode11 len", nb, 13);
    chk("R8 mid", {data_hi, data_lo}, 16'h0155);
  endtask

  task automatic t_pin();
    int nb, nt;
    vin = 10'h0F0;
    wr(8'hC8);
    chk("R5 track pin low", track_o, 1);
    cnv_pin = 1'b1;
    @(negedge clk);
    chk("R5 sync1 busy", cfg_rdata[4], 0);
    chk("R5 sync1 track", track_o, 1);
    @(negedge clk);
    chk("R5 sync2 track", track_o, 0);
    chk("R5 sync2 busy", cfg_rdata[4], 0);
    @(negedge clk);
    chk("R5 start", cfg_rdata[4], 1);
    measure(-1, nb, nt);
    chk("R5 conv len", nb, 10);
    chk("R8 pin result", {data_hi, data_lo}, 16'h00F0);
    idle_for(5, "R5 held high");
    cnv_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 track again", track_o, 1);
  endtask

  task automatic t_disabled();
    wr(8'h04);
    chk("R11 track off", track_o, 0);
    pulse_a();
    chk("R11 timer", cfg_rdata[4], 0);
    wr(8'h10);
    chk("R11 soft", cfg_rdata[4], 0);
    idle_for(3, "R11 quiet");
  endtask

  task automatic t_window();
    @(negedge clk); win_hit = 1'b1;
    @(negedge clk); win_hit = 1'b0;
    chk("R13 set", cfg_rdata[1], 1);
    wr(8'h06);
    chk("R13 write1 keeps", cfg_rdata[1], 1);
    wr(8'h04);
    chk("R13 clear", cfg_rdata[1], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_layout();
    t_soft_tm1();
    t_flags();
    t_justify();
    t_tm0();
    t_timers();
    t_pin();
    t_disabled();
    t_window();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule